// File: doc/BRIEF.md
# DLL Enable and Tuning-Step Setup Sequencer

This block prepares a storage-card host PHY for high-speed sampling-point tuning. When asked, it checks that the card clock runs above 52 MHz. It then takes the delay-locked loop out of bypass: it reads the DLL control register and writes back a word that enables the loop, selects fast lock, sets both phase selects to 90 degrees and sets the update bit for the PHY generation in use. After that it polls the lock indication on a fixed interval until lock is seen or a deadline passes.

Once the loop is locked, or was already enabled, the block divides the measured DLL delay by a programmable divider to get the tuning step. A step too large for its field is saturated. The block then writes the step and the required number of consecutive good samples into the tuning-control register. Every request ends with a one-cycle done pulse and a two-bit status code. The caller holds the data inputs stable while a request is in progress.

Top module: `dll_tune_setup`

## Requirements
- R1: A start request while `fast_clk_i` is low ends with a done pulse one cycle later with status 01 (rejected). Neither register is written.
- R2: If bit 31 of `dll_ctrl_rd_i` is set when the request is accepted, no DLL control write is issued. The block goes straight to the step computation and the tuning-control write.
- R3: The DLL control write equals the read value with bit 31 (enable) and bit 5 (fast lock) set and bit 0 (bypass) cleared. Bits not named in R3, R4 or R5 pass through unchanged.
- R4: In the DLL control write, both 6-bit phase-select fields, bits [21:16] and [29:24], hold 0x1F.
- R5: With `variant_new_i` = 0, the write sets bit 30 (update strobe). With `variant_new_i` = 1, it sets bit 23 (update) and clears bit 30 (reference-clock select).
- R6: After the DLL write, `lock_i` is sampled once every POLL_US microseconds of the CLK_KHZ clock. If no sample sees lock within TIMEOUT_US, the request ends with status 10 (timeout) and no tuning-control write.
- R7: When locked, step = floor(`cur_dly_i` / `step_div_i`). If the step fits the STEP_W-bit field, the request ends with status 00.
- R8: A divider of 0, or a quotient above 2^STEP_W-1, gives a step of 2^STEP_W-1 and status 11 (clamped).
- R9: The tuning-control write equals `tun_ctrl_rd_i` with bits [STEP_LSB +: STEP_W] replaced by the step and bits [CNT_LSB +: CNT_W] replaced by `pass_cnt_i`. All other bits are unchanged. Defaults: step in [23:16], count in [11:8].
- R10: `done_o` is high for exactly one cycle per request, and `status_o` is valid while it is high. After reset, `done_o`, `dll_ctrl_we_o` and `tun_ctrl_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, accepted when idle |
| fast_clk_i | input | 1 | High when the card clock is above 52 MHz |
| variant_new_i | input | 1 | 0: older PHY generation, 1: newer |
| dll_ctrl_rd_i | input | 32 | Current DLL control register value |
| dll_ctrl_wr_o | output | 32 | DLL control write data |
| dll_ctrl_we_o | output | 1 | DLL control write strobe |
| lock_i | input | 1 | DLL lock status |
| cur_dly_i | input | DLY_W | Measured DLL delay value |
| step_div_i | input | DIV_W | Tuning-step divider |
| pass_cnt_i | input | CNT_W | Consecutive-success count to program |
| tun_ctrl_rd_i | input | 32 | Current tuning-control register value |
| tun_ctrl_wr_o | output | 32 | Tuning-control write data |
| tun_ctrl_we_o | output | 1 | Tuning-control write strobe |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 00 ok, 01 rejected, 10 timeout, 11 clamped |

## Verification
Some rules are checked by assertions on every cycle:
- a rejected request writes nothing and reports status 01;
- an already-enabled DLL is never rewritten;
- done lasts one cycle;
- a tuning write coincides with a done pulse carrying ok or clamped;
- a clamped write carries the field maximum;
- the poll counter stays inside its window;
- the divider remainder stays below the divisor.

Other behaviour can only be shown by the bench's scenarios:
- the exact bit pattern of the DLL write for each variant;
- the quotient value;
- the field merge into the tuning-control word;
- how long the request runs before a timeout.

These are compared against reference models in the bench, over random vectors and the quotient boundary at 255 and 256.

// File: rtl/dtu_pkg.sv
package dtu_pkg;

   localparam int REG_W = 32;

   // DLL control bit positions (decoded by the PHY, so fixed)
   localparam int DLL_EN_BIT     = 31;
   localparam int DLL_OLD_UPD    = 30;
   localparam int DLL_REFSEL_BIT = 30;
   localparam int DLL_NEW_UPD    = 23;
   localparam int DLL_FAST_BIT   = 5;
   localparam int DLL_BYPASS_BIT = 0;
   localparam int PHASE_W        = 6;
   localparam int PHASE_LSB_A    = 16;
   localparam int PHASE_LSB_B    = 24;
   localparam logic [PHASE_W-1:0] PHASE_90 = 6'h1F;

   typedef enum logic [1:0] {
      ST_OK      = 2'b00,
      ST_REJECT  = 2'b01,
      ST_TIMEOUT = 2'b10,
      ST_CLAMP   = 2'b11
   } dtu_status_t;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_LOCK = 2'd1,
      S_DIV  = 2'd2
   } dtu_state_t;

endpackage

// File: rtl/dtu_dll_word.sv
module dtu_dll_word
   import dtu_pkg::*;
(
   input  logic [REG_W-1:0] rd_i,
   input  logic             variant_new_i,
   output logic [REG_W-1:0] word_o
);

   localparam int N_PHASE = 2;

   logic [N_PHASE-1:0][REG_W-1:0] ph_mask;
   logic [N_PHASE-1:0][REG_W-1:0] ph_val;

   generate
      for (genvar g = 0; g < N_PHASE; g++) begin : g_phase
         localparam int LSB = (g == 0) ? PHASE_LSB_A : PHASE_LSB_B;
         assign ph_mask[g] = {{(REG_W-PHASE_W){1'b0}}, {PHASE_W{1'b1}}} << LSB;
         assign ph_val[g]  = {{(REG_W-PHASE_W){1'b0}}, PHASE_90} << LSB;
      end
   endgenerate

   logic [REG_W-1:0] clr_all;
   logic [REG_W-1:0] set_all;

   always_comb begin
      clr_all = '0;
      set_all = '0;
      for (int i = 0; i < N_PHASE; i++) begin
         clr_all = clr_all | ph_mask[i];
         set_all = set_all | ph_val[i];
      end
   end

   always_comb begin
      word_o                 = (rd_i & ~clr_all) | set_all;
      word_o[DLL_EN_BIT]     = 1'b1;
      word_o[DLL_FAST_BIT]   = 1'b1;
      word_o[DLL_BYPASS_BIT] = 1'b0;
      if (variant_new_i) begin
         word_o[DLL_NEW_UPD]    = 1'b1;
         word_o[DLL_REFSEL_BIT] = 1'b0;
      end else begin
         word_o[DLL_OLD_UPD]    = 1'b1;
      end
   end

endmodule

// File: rtl/dtu_lock_timer.sv
module dtu_lock_timer #(
   parameter int POLL_CYCLES   = 20000,
   parameter int TIMEOUT_POLLS = 320
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic lock_i,
   output logic locked_o,
   output logic expired_o
);

   localparam int PRE_W  = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
   localparam int POLL_W = $clog2(TIMEOUT_POLLS + 1);

   generate
      if (POLL_CYCLES < 1) begin : g_bad_poll
         $error("POLL_CYCLES must be at least 1");
      end
      if (TIMEOUT_POLLS < 1) begin : g_bad_tmo
         $error("TIMEOUT_POLLS must be at least 1");
      end
   endgenerate

   logic              active;
   logic [PRE_W-1:0]  pre;
   logic [POLL_W-1:0] polls;
   logic              tick;

   assign tick = (pre == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         pre       <= '0;
         polls     <= '0;
         locked_o  <= 1'b0;
         expired_o <= 1'b0;
      end else begin
         locked_o  <= 1'b0;
         expired_o <= 1'b0;
         if (arm_i) begin
            active <= 1'b1;
            pre    <= '0;
            polls  <= '0;
         end else if (active) begin
            pre <= (pre == PRE_W'(POLL_CYCLES - 1)) ? '0 : pre + 1'b1;
            if (tick) begin
               if (lock_i) begin
                  locked_o <= 1'b1;
                  active   <= 1'b0;
               end else if (polls == POLL_W'(TIMEOUT_POLLS)) begin
                  expired_o <= 1'b1;
                  active    <= 1'b0;
               end else begin
                  polls <= polls + 1'b1;
               end
            end
         end
      end
   end

   // R6
   poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      polls <= POLL_W'(TIMEOUT_POLLS));

   // R6
   single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(locked_o && expired_o));

endmodule

// File: rtl/dtu_divider.sv
module dtu_divider #(
   parameter int N_W = 12,
   parameter int D_W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go_i,
   input  logic [N_W-1:0] dividend_i,
   input  logic [D_W-1:0] divisor_i,
   output logic           valid_o,
   output logic [N_W-1:0] quot_o,
   output logic           dz_o
);

   localparam int C_W = $clog2(N_W + 1);

   generate
      if (N_W < 2) begin : g_bad_n
         $error("dividend width must be at least 2");
      end
   endgenerate

   logic [D_W-1:0] rem;
   logic [N_W-1:0] quo;
   logic [D_W-1:0] dvs;
   logic [C_W-1:0] cnt;
   logic [D_W:0]   trial;
   logic           fits;

   assign trial = {rem, quo[N_W-1]};
   assign fits  = (trial >= {1'b0, dvs});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem     <= '0;
         quo     <= '0;
         dvs     <= '0;
         cnt     <= '0;
         valid_o <= 1'b0;
         dz_o    <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (go_i) begin
            rem  <= '0;
            quo  <= dividend_i;
            dvs  <= divisor_i;
            dz_o <= (divisor_i == '0);
            cnt  <= C_W'(N_W);
         end else if (cnt != '0) begin
            rem     <= fits ? D_W'(trial - {1'b0, dvs}) : D_W'(trial);
            quo     <= {quo[N_W-2:0], fits};
            cnt     <= cnt - 1'b1;
            valid_o <= (cnt == C_W'(1));
         end
      end
   end

   assign quot_o = quo;

   // R7
   rem_below_dvs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && dvs != '0) |-> (rem < dvs));

endmodule

// File: rtl/dll_tune_setup.sv
module dll_tune_setup
   import dtu_pkg::*;
#(
   parameter int CLK_KHZ    = 200000,
   parameter int POLL_US    = 100,
   parameter int TIMEOUT_US = 32000,
   parameter int DLY_W      = 12,
   parameter int DIV_W      = 8,
   parameter int STEP_W     = 8,
   parameter int STEP_LSB   = 16,
   parameter int CNT_W      = 4,
   parameter int CNT_LSB    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              fast_clk_i,
   input  logic              variant_new_i,
   input  logic [31:0]       dll_ctrl_rd_i,
   output logic [31:0]       dll_ctrl_wr_o,
   output logic              dll_ctrl_we_o,
   input  logic              lock_i,
   input  logic [DLY_W-1:0]  cur_dly_i,
   input  logic [DIV_W-1:0]  step_div_i,
   input  logic [CNT_W-1:0]  pass_cnt_i,
   input  logic [31:0]       tun_ctrl_rd_i,
   output logic [31:0]       tun_ctrl_wr_o,
   output logic              tun_ctrl_we_o,
   output logic              done_o,
   output logic [1:0]        status_o
);

   localparam int POLL_CYCLES   = (CLK_KHZ * POLL_US) / 1000;
   localparam int TIMEOUT_POLLS = TIMEOUT_US / POLL_US;
   localparam int STEP_MAX      = (1 << STEP_W) - 1;

   generate
      if (STEP_W > DLY_W) begin : g_bad_step
         $error("step field wider than delay value");
      end
      if (STEP_LSB + STEP_W > REG_W || CNT_LSB + CNT_W > REG_W) begin : g_bad_pos
         $error("tuning fields exceed register width");
      end
      if (!(CNT_LSB + CNT_W <= STEP_LSB || STEP_LSB + STEP_W <= CNT_LSB)) begin : g_overlap
         $error("tuning fields overlap");
      end
   endgenerate

   dtu_state_t       state;
   logic             accept, reject, skip_en, do_en;
   logic             locked, expired;
   logic             div_go, div_valid, div_dz;
   logic [DLY_W-1:0] quot;
   logic [REG_W-1:0] en_word;
   logic             over;
   logic [STEP_W-1:0] step;
   logic [REG_W-1:0] tun_word;

   assign accept  = (state == S_IDLE) && start_i;
   assign reject  = accept && !fast_clk_i;
   assign skip_en = accept && fast_clk_i && dll_ctrl_rd_i[DLL_EN_BIT];
   assign do_en   = accept && fast_clk_i && !dll_ctrl_rd_i[DLL_EN_BIT];
   assign div_go  = skip_en || ((state == S_LOCK) && locked);

   dtu_dll_word u_word (
      .rd_i          (dll_ctrl_rd_i),
      .variant_new_i (variant_new_i),
      .word_o        (en_word)
   );

   dtu_lock_timer #(
      .POLL_CYCLES   (POLL_CYCLES),
      .TIMEOUT_POLLS (TIMEOUT_POLLS)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_i     (do_en),
      .lock_i    (lock_i),
      .locked_o  (locked),
      .expired_o (expired)
   );

   dtu_divider #(
      .N_W (DLY_W),
      .D_W (DIV_W)
   ) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_i       (div_go),
      .dividend_i (cur_dly_i),
      .divisor_i  (step_div_i),
      .valid_o    (div_valid),
      .quot_o     (quot),
      .dz_o       (div_dz)
   );

   always_comb begin
      over     = div_dz || (quot > DLY_W'(STEP_MAX));
      step     = over ? {STEP_W{1'b1}} : quot[STEP_W-1:0];
      tun_word = tun_ctrl_rd_i;
      tun_word[STEP_LSB +: STEP_W] = step;
      tun_word[CNT_LSB +: CNT_W]   = pass_cnt_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= S_IDLE;
         dll_ctrl_wr_o <= '0;
         dll_ctrl_we_o <= 1'b0;
         tun_ctrl_wr_o <= '0;
         tun_ctrl_we_o <= 1'b0;
         done_o        <= 1'b0;
         status_o      <= ST_OK;
      end else begin
         dll_ctrl_we_o <= 1'b0;
         tun_ctrl_we_o <= 1'b0;
         done_o        <= 1'b0;
         unique case (state)
            S_IDLE: begin
               if (reject) begin
                  done_o   <= 1'b1;
                  status_o <= ST_REJECT;
               end else if (do_en) begin
                  dll_ctrl_wr_o <= en_word;
                  dll_ctrl_we_o <= 1'b1;
                  state         <= S_LOCK;
               end else if (skip_en) begin
                  state <= S_DIV;
               end
            end
            S_LOCK: begin
               if (locked) begin
                  state <= S_DIV;
               end else if (expired) begin
                  done_o   <= 1'b1;
                  status_o <= ST_TIMEOUT;
                  state    <= S_IDLE;
               end
            end
            S_DIV: begin
               if (div_valid) begin
                  tun_ctrl_wr_o <= tun_word;
                  tun_ctrl_we_o <= 1'b1;
                  done_o        <= 1'b1;
                  status_o      <= over ? ST_CLAMP : ST_OK;
                  state         <= S_IDLE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R1
   reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && start_i && !fast_clk_i) |=>
      (done_o && status_o == ST_REJECT && !dll_ctrl_we_o && !tun_ctrl_we_o));

   // R2
   no_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && start_i && fast_clk_i && dll_ctrl_rd_i[DLL_EN_BIT]) |=>
      !dll_ctrl_we_o);

   // R3
   dll_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dll_ctrl_we_o |-> (dll_ctrl_wr_o[DLL_EN_BIT] && dll_ctrl_wr_o[DLL_FAST_BIT]
                         && !dll_ctrl_wr_o[DLL_BYPASS_BIT]));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   tun_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tun_ctrl_we_o |-> (done_o && (status_o == ST_OK || status_o == ST_CLAMP)));

   // R8
   clamp_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tun_ctrl_we_o && status_o == ST_CLAMP) |->
      (tun_ctrl_wr_o[STEP_LSB +: STEP_W] == {STEP_W{1'b1}}));

   // R6
   timeout_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && status_o == ST_TIMEOUT) |-> !tun_ctrl_we_o);

endmodule

// File: tb/dll_tune_setup_bench.sv
module dll_tune_setup_bench;

   localparam int CLK_KHZ    = 100;
   localparam int POLL_US    = 100;
   localparam int TIMEOUT_US = 32000;
   localparam int TMO_CYC    = (CLK_KHZ * POLL_US / 1000) * (TIMEOUT_US / POLL_US);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        fast_clk_i = 1'b0;
   logic        variant_new_i = 1'b0;
   logic [31:0] dll_ctrl_rd_i = '0;
   logic [31:0] dll_ctrl_wr_o;
   logic        dll_ctrl_we_o;
   logic        lock_i = 1'b0;
   logic [11:0] cur_dly_i = '0;
   logic [7:0]  step_div_i = '0;
   logic [3:0]  pass_cnt_i = '0;
   logic [31:0] tun_ctrl_rd_i = '0;
   logic [31:0] tun_ctrl_wr_o;
   logic        tun_ctrl_we_o;
   logic        done_o;
   logic [1:0]  status_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   dll_tune_setup #(
      .CLK_KHZ    (CLK_KHZ),
      .POLL_US    (POLL_US),
      .TIMEOUT_US (TIMEOUT_US)
   ) u_dll_tune_setup (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .fast_clk_i    (fast_clk_i),
      .variant_new_i (variant_new_i),
      .dll_ctrl_rd_i (dll_ctrl_rd_i),
      .dll_ctrl_wr_o (dll_ctrl_wr_o),
      .dll_ctrl_we_o (dll_ctrl_we_o),
      .lock_i        (lock_i),
      .cur_dly_i     (cur_dly_i),
      .step_div_i    (step_div_i),
      .pass_cnt_i    (pass_cnt_i),
      .tun_ctrl_rd_i (tun_ctrl_rd_i),
      .tun_ctrl_wr_o (tun_ctrl_wr_o),
      .tun_ctrl_we_o (tun_ctrl_we_o),
      .done_o        (done_o),
      .status_o      (status_o)
   );

   function automatic logic [31:0] exp_dll(input logic [31:0] rd, input logic newv);
      logic [31:0] w;
      w = rd;
      w[31] = 1'b1;
      w[5]  = 1'b1;
      w[0]  = 1'b0;
      w[21:16] = 6'h1F;
      w[29:24] = 6'h1F;
      if (newv) begin
         w[23] = 1'b1;
         w[30] = 1'b0;
      end else begin
         w[30] = 1'b1;
      end
      return w;
   endfunction

   function automatic logic exp_clamp(input logic [11:0] dly, input logic [7:0] dv);
      if (dv == 0) return 1'b1;
      return (dly / dv) > 255;
   endfunction

   function automatic logic [31:0] exp_tun(input logic [31:0] rd, input logic [11:0] dly,
                                           input logic [7:0] dv, input logic [3:0] cnt);
      logic [31:0] w;
      logic [11:0] q;
      w = rd;
      q = (dv == 0) ? 12'hFFF : dly / dv;
      w[23:16] = exp_clamp(dly, dv) ? 8'hFF : q[7:0];
      w[11:8]  = cnt;
      return w;
   endfunction

   task automatic chk(input logic ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic run_vec(input logic hs, input logic newv, input logic [31:0] rd_dll,
                          input logic [11:0] dly, input logic [7:0] dv, input logic [3:0] cnt,
                          input logic [31:0] rd_tun, input int lock_dly);
      int cyc = 0, we_cyc = -1, done_cyc = -1, n_dll = 0, n_tun = 0;
      logic [31:0] dll_w = '0, tun_w = '0;
      logic [1:0] st = 2'b00;
      logic [1:0] est;
      logic en_already;
      fast_clk_i = hs; variant_new_i = newv; dll_ctrl_rd_i = rd_dll;
      cur_dly_i = dly; step_div_i = dv; pass_cnt_i = cnt; tun_ctrl_rd_i = rd_tun;
      lock_i = 1'b0;
      en_already = rd_dll[31];
      start_i = 1'b1;
      while (done_cyc < 0 && cyc < TMO_CYC + 2000) begin
         @(negedge clk);
         start_i = 1'b0;
         cyc++;
         if (dll_ctrl_we_o) begin n_dll++; dll_w = dll_ctrl_wr_o; we_cyc = cyc; end
         if (tun_ctrl_we_o) begin n_tun++; tun_w = tun_ctrl_wr_o; end
         if (done_o) begin done_cyc = cyc; st = status_o; end
         if (we_cyc >= 0 && lock_dly >= 0 && (cyc - we_cyc) >= lock_dly) lock_i = 1'b1;
      end
      chk(done_cyc >= 0, "R10", "done seen", 32'(done_cyc), 32'd1);
      @(negedge clk);
      chk(!done_o, "R10", "done one cycle", {31'd0, done_o}, 32'd0);
      lock_i = 1'b0;

      if (!hs) est = 2'b01;
      else if (!en_already && lock_dly < 0) est = 2'b10;
      else if (exp_clamp(dly, dv)) est = 2'b11;
      else est = 2'b00;
      chk(st == est, (est == 2'b01) ? "R1" : (est == 2'b10) ? "R6" : (est == 2'b11) ? "R8" : "R7",
          "status", {30'd0, st}, {30'd0, est});

      if (!hs || en_already) begin
         chk(n_dll == 0, hs ? "R2" : "R1", "no DLL write", 32'(n_dll), 32'd0);
      end else begin
         chk(n_dll == 1 && dll_w == exp_dll(rd_dll, newv), "R3/R4/R5", "DLL word",
             dll_w, exp_dll(rd_dll, newv));
      end

      if (est == 2'b00 || est == 2'b11) begin
         chk(n_tun == 1 && tun_w == exp_tun(rd_tun, dly, dv, cnt), "R9", "tuning word",
             tun_w, exp_tun(rd_tun, dly, dv, cnt));
      end else begin
         chk(n_tun == 0, "R6", "no tuning write", 32'(n_tun), 32'd0);
      end

      if (est == 2'b10) begin
         chk((done_cyc - we_cyc) >= TMO_CYC && (done_cyc - we_cyc) <= TMO_CYC + 10,
             "R6", "timeout length", 32'(done_cyc - we_cyc), 32'(TMO_CYC));
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 199000);
      n_bad++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      chk(!done_o && !dll_ctrl_we_o && !tun_ctrl_we_o, "R10", "reset outputs",
          {29'd0, done_o, dll_ctrl_we_o, tun_ctrl_we_o}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 rejected at or below 52 MHz
      run_vec(1'b0, 1'b1, 32'h0000_0001, 12'd500, 8'd4, 4'd3, 32'hFFFF_FFFF, 5);
      // R2 already enabled
      run_vec(1'b1, 1'b1, 32'h8000_0000, 12'd400, 8'd4, 4'd6, 32'h1234_5678, -1);
      // R5 old variant
      run_vec(1'b1, 1'b0, 32'h0000_0001, 12'd300, 8'd3, 4'd5, 32'h0, 7);
      // R5 new variant with reference-clock select set
      run_vec(1'b1, 1'b1, 32'h40C0_0041, 12'd300, 8'd3, 4'd5, 32'hFFFF_FFFF, 0);
      // R8 divider zero
      run_vec(1'b1, 1'b0, 32'h0, 12'd10, 8'd0, 4'd1, 32'hA5A5_A5A5, 3);
      // R7 boundary: 255 fits
      run_vec(1'b1, 1'b1, 32'h0, 12'd255, 8'd1, 4'd15, 32'h0, 2);
      // R8 boundary: 256 clamps
      run_vec(1'b1, 1'b1, 32'h0, 12'd256, 8'd1, 4'd15, 32'h0, 2);
      // R7 zero delay
      run_vec(1'b1, 1'b0, 32'hFFFF_FFFE, 12'd0, 8'd9, 4'd2, 32'h0F0F_0F0F, 25);
      // R6 lock never arrives
      run_vec(1'b1, 1'b1, 32'h0000_1000, 12'd100, 8'd2, 4'd4, 32'h0, -1);

      for (int i = 0; i < 40; i++) begin
         logic hs, newv;
         logic [31:0] rdd;
         logic [7:0] dv;
         hs   = ($urandom_range(7) != 0);
         newv = $urandom_range(1);
         rdd  = $urandom;
         rdd[31] = ($urandom_range(3) == 0);
         dv   = ($urandom_range(3) == 0) ? 8'($urandom_range(3)) : 8'($urandom);
         run_vec(hs, newv, rdd, 12'($urandom), dv, 4'($urandom), $urandom,
                 $urandom_range(150));
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule